// File: doc/BRIEF.md
# Multi-Producer Partitioned Token Buffer

This block sits in front of one consuming function in a statically scheduled dataflow fabric. Six producers each deliver 7-bit tokens through a set of crossbar ports. A per-port route field tells the buffer which producer a port is carrying in the current cycle. Storage is cut into six equal regions, one per producer. Each region has its own write offset and occupancy, so producers can fill their regions at different rates. A single read offset is shared by all regions, because one consumer firing always takes exactly one token from every region.

Each producer side is a valid/ready stream. A token moves when `prod_valid[p]` and `prod_ready[p]` are both high, and `prod_ready` never depends on `prod_valid`. The consumer side works the same way. `tok_avail` acts as valid and goes high once every region holds a token. `cons_ready` is the consumer's ready, and a firing happens when both are high. The result leaves as a one-cycle pulse on `res_valid`, and this stream has no back-pressure. The attached function is picked at build time: a descending sorter or a pass-through in producer order.

The region depth follows the schedule the block serves. With one entry per region, the block fits a schedule that fires every other cycle. With two entries, a write and a firing overlap in the same cycle, so the consumer can produce a result every cycle.

Top module: `tkb_buffer`

## Requirements
- R1: After reset every stored entry is zero, all offsets sit at the start of their regions, `prod_ready` is all ones, and `tok_avail`, `res_valid` and `res_data` are zero.
- R2: Producer p stores a token only in a cycle where `prod_valid[p]` and `prod_ready[p]` are both high. The token is taken from the lowest-numbered port k whose route field `xbar_route[k*3 +: 3]` equals p, or is zero if no port carries p. Port k's data is `xbar_data[k*7 +: 7]`.
- R3: `prod_ready[p]` is high exactly when region p holds fewer than REGION_DEPTH tokens, and a region never holds more than REGION_DEPTH tokens.
- R4: `tok_avail` is high exactly when every region holds at least one token. A firing happens when `tok_avail` and `cons_ready` are both high, and it removes the oldest token from every region.
- R5: `res_valid` is high in the cycle after a firing, and only then. Lane i of the result is `res_data[i*7 +: 7]`.
- R6: In every cycle where `res_valid` is low, `res_data` is all zeros.
- R7: In the sorting variant, lane 0 holds the largest of the six consumed tokens and the lanes descend from there. Equal values are all kept.
- R8: In the pass-through variant, lane p holds the token consumed from producer p.
- R9: With REGION_DEPTH 2, a write into a region and a firing from it can happen in the same cycle. Under steady producer traffic with `cons_ready` held high, this gives one result per cycle.
- R10: With REGION_DEPTH 1, steady producer traffic with `cons_ready` held high gives at most one result every other cycle.
- R11: Each region hands out its tokens in the order they were stored, and each region wraps within its own bounds independently of the others, even when producers write at different rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prod_valid | input | NPROD | Producer p offers a token this cycle |
| prod_ready | output | NPROD | Region p has room for a token |
| xbar_data | input | NPORT*W | Crossbar port data, port k at [k*W +: W] |
| xbar_route | input | NPORT*SEL_W | Producer index carried by port k at [k*SEL_W +: SEL_W] |
| tok_avail | output | 1 | Every region holds at least one token |
| cons_ready | input | 1 | Consumer accepts a firing |
| res_valid | output | 1 | Result of the previous cycle's firing is present |
| res_data | output | NPROD*W | Result vector, lane i at [i*W +: W]; zero when not valid |

## Verification
Two things can land in one cycle: a producer write into a region and a consumer firing that drains the same region. With two entries per region, this overlap is what sustains one result per clock. The bench provokes it by holding every `prod_valid` and `cons_ready` high for a long stretch. Two instances run in parallel, one with depth 2 and sorting, the other with depth 1 and pass-through. The bench judges each instance in two ways. It checks that every result matches a per-region reference queue, which confirms that simultaneous writes neither overwrite the slot being read nor get lost. It also counts the results in that stretch against the one-per-cycle and one-per-two-cycles bounds.

// File: rtl/tkb_pkg.sv
package tkb_pkg;

  typedef enum logic {
    CONS_IDENTITY  = 1'b0,
    CONS_SORT_DESC = 1'b1
  } cons_kind_e;

  // Next offset inside a region of 'depth' entries, wrapping to zero.
  function automatic int wrap_next(input int off, input int depth);
    return (off >= depth - 1) ? 0 : off + 1;
  endfunction

endpackage

// File: rtl/tkb_region.sv
module tkb_region #(
  parameter int W     = 7,
  parameter int DEPTH = 2,
  parameter int OFF_W = 1,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  input  logic [OFF_W-1:0] rd_off,
  output logic [W-1:0]     rd_data,
  output logic [CNT_W-1:0] occ
);
  import tkb_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + CNT_W'(wr_en) - CNT_W'(rd_en);
  end

  generate
    if (DEPTH == 1) begin : g_single
      logic [W-1:0] slot;
      logic         unused_off;
      assign unused_off = ^rd_off;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     slot <= '0;
        else if (wr_en) slot <= wr_data;
      end
      assign rd_data = slot;
    end else begin : g_multi
      logic [W-1:0]     mem [DEPTH];
      logic [OFF_W-1:0] wr_off;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wr_off <= '0;
          for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
          mem[wr_off] <= wr_data;
          wr_off      <= OFF_W'(wrap_next(int'(wr_off), DEPTH));
        end
      end
      assign rd_data = mem[rd_off];
    end
  endgenerate

endmodule

// File: rtl/tkb_consume.sv
module tkb_consume #(
  parameter int NPROD = 6,
  parameter int W     = 7,
  parameter tkb_pkg::cons_kind_e KIND = tkb_pkg::CONS_SORT_DESC
) (
  input  logic [NPROD*W-1:0] vec_in,
  output logic [NPROD*W-1:0] vec_out
);
  import tkb_pkg::*;

  generate
    if (KIND == CONS_SORT_DESC) begin : g_sort
      // Rank each value by how many others beat it (ties broken by index),
      // then scatter it to that lane: a stable descending order.
      always_comb begin
        vec_out = '0;
        for (int i = 0; i < NPROD; i++) begin
          int rank;
          rank = 0;
          for (int j = 0; j < NPROD; j++) begin
            if ((vec_in[j*W +: W] > vec_in[i*W +: W]) ||
                ((vec_in[j*W +: W] == vec_in[i*W +: W]) && (j < i)))
              rank = rank + 1;
          end
          vec_out[rank*W +: W] = vec_in[i*W +: W];
        end
      end
    end else begin : g_ident
      assign vec_out = vec_in;
    end
  endgenerate

endmodule

// File: rtl/tkb_buffer.sv
module tkb_buffer #(
  parameter int NPROD        = 6,
  parameter int NPORT        = 6,
  parameter int W            = 7,
  parameter int REGION_DEPTH = 2,
  parameter tkb_pkg::cons_kind_e KIND = tkb_pkg::CONS_SORT_DESC,
  localparam int SEL_W = (NPROD > 1) ? $clog2(NPROD) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPROD-1:0]       prod_valid,
  output logic [NPROD-1:0]       prod_ready,
  input  logic [NPORT*W-1:0]     xbar_data,
  input  logic [NPORT*SEL_W-1:0] xbar_route,
  output logic                   tok_avail,
  input  logic                   cons_ready,
  output logic                   res_valid,
  output logic [NPROD*W-1:0]     res_data
);
  import tkb_pkg::*;

  localparam int OFF_W = (REGION_DEPTH > 1) ? $clog2(REGION_DEPTH) : 1;
  localparam int CNT_W = $clog2(REGION_DEPTH + 1);
  localparam int VEC_W = NPROD * W;

  logic [OFF_W-1:0]       rd_off;
  logic [NPROD-1:0]       nonempty;
  logic [NPROD*CNT_W-1:0] occ_flat;
  logic [VEC_W-1:0]       rd_vec;
  logic [VEC_W-1:0]       cons_out;
  logic                   fire;

  genvar p;
  generate
    for (p = 0; p < NPROD; p++) begin : g_prod
      logic [W-1:0]     in_tok;
      logic [CNT_W-1:0] occ;
      logic             wr_en;

      // Lowest port whose route names this producer wins.
      always_comb begin
        in_tok = '0;
        for (int k = NPORT - 1; k >= 0; k--) begin
          if (xbar_route[k*SEL_W +: SEL_W] == SEL_W'(p))
            in_tok = xbar_data[k*W +: W];
        end
      end

      assign prod_ready[p] = (occ < CNT_W'(REGION_DEPTH));
      assign nonempty[p]   = (occ != '0);
      assign wr_en         = prod_valid[p] & prod_ready[p];
      assign occ_flat[p*CNT_W +: CNT_W] = occ;

      tkb_region #(
        .W(W), .DEPTH(REGION_DEPTH), .OFF_W(OFF_W), .CNT_W(CNT_W)
      ) u_region (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (in_tok),
        .rd_en   (fire),
        .rd_off  (rd_off),
        .rd_data (rd_vec[p*W +: W]),
        .occ     (occ)
      );
    end
  endgenerate

  assign tok_avail = &nonempty;
  assign fire      = tok_avail & cons_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rd_off <= '0;
    else if (fire) rd_off <= OFF_W'(wrap_next(int'(rd_off), REGION_DEPTH));
  end

  tkb_consume #(.NPROD(NPROD), .W(W), .KIND(KIND)) u_consume (
    .vec_in  (rd_vec),
    .vec_out (cons_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= fire;
      res_data  <= fire ? cons_out : '0;
    end
  end

endmodule

// File: rtl/tkb_buffer_chk.sv
module tkb_buffer_chk #(
  parameter int NPROD = 6,
  parameter int W     = 7,
  parameter int DEPTH = 2,
  parameter int CNT_W = 2,
  parameter bit SORT  = 1'b1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NPROD*CNT_W-1:0] occ_flat,
  input logic                   fire,
  input logic                   res_valid,
  input logic [NPROD*W-1:0]     res_data
);

  logic sorted_ok;
  always_comb begin
    sorted_ok = 1'b1;
    for (int i = 0; i + 1 < NPROD; i++)
      if (res_data[i*W +: W] < res_data[(i+1)*W +: W]) sorted_ok = 1'b0;
  end

  genvar p;
  generate
    for (p = 0; p < NPROD; p++) begin : g_occ
      p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        occ_flat[p*CNT_W +: CNT_W] <= CNT_W'(DEPTH));
      p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_flat[p*CNT_W +: CNT_W] == CNT_W'(DEPTH)) && !fire
        |=> occ_flat[p*CNT_W +: CNT_W] == CNT_W'(DEPTH));
    end
  endgenerate

  p_fire_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> res_valid);
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !res_valid);
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> res_data == '0);
  p_sorted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (SORT && res_valid) |-> sorted_ok);

endmodule

bind tkb_buffer tkb_buffer_chk #(
  .NPROD (NPROD),
  .W     (W),
  .DEPTH (REGION_DEPTH),
  .CNT_W (CNT_W),
  .SORT  (KIND == tkb_pkg::CONS_SORT_DESC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .occ_flat  (occ_flat),
  .fire      (fire),
  .res_valid (res_valid),
  .res_data  (res_data)
);

// File: tb/tb_tkb_buffer.sv
`timescale 1ns/1ps
module tb_tkb_buffer;
  import tkb_pkg::*;

  localparam int NP = 6;
  localparam int W  = 7;
  localparam int VW = NP * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NP-1:0]   pv;
  logic [VW-1:0]   xd;
  logic [NP*3-1:0] xr;
  logic            cr;

  logic [NP-1:0] rdy0, rdy1;
  logic          av0, av1, rv0, rv1;
  logic [VW-1:0] rd0, rd1;

  tkb_buffer #(.REGION_DEPTH(2), .KIND(CONS_SORT_DESC)) dut (
    .clk(clk), .rst_n(rst_n), .prod_valid(pv), .prod_ready(rdy0),
    .xbar_data(xd), .xbar_route(xr), .tok_avail(av0), .cons_ready(cr),
    .res_valid(rv0), .res_data(rd0));

  tkb_buffer #(.REGION_DEPTH(1), .KIND(CONS_IDENTITY)) dut_id (
    .clk(clk), .rst_n(rst_n), .prod_valid(pv), .prod_ready(rdy1),
    .xbar_data(xd), .xbar_route(xr), .tok_avail(av1), .cons_ready(cr),
    .res_valid(rv1), .res_data(rd1));

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  // Reference model per instance: region slots, counts, shared read offset.
  logic [W-1:0]  mq   [2][NP][2];
  int            mcnt [2][NP];
  int            mrd  [2];
  int            dep  [2] = '{2, 1};
  logic          pend [2];
  logic [VW-1:0] expq0[$];
  logic [VW-1:0] expq1[$];
  int            nres [2];

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) %s: actual %0h expected %0h", tag, phase, what, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] sort_desc(input logic [VW-1:0] v);
    logic [W-1:0] a [NP];
    logic [W-1:0] t;
    logic [VW-1:0] r;
    for (int i = 0; i < NP; i++) a[i] = v[i*W +: W];
    for (int i = 0; i < NP; i++)
      for (int j = 0; j + 1 < NP - i; j++)
        if (a[j] < a[j+1]) begin t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
    for (int i = 0; i < NP; i++) r[i*W +: W] = a[i];
    return r;
  endfunction

  task automatic check_outputs(input int i);
    logic [NP-1:0] rdy;
    logic          av, rv;
    logic [VW-1:0] rd;
    logic [VW-1:0] e;
    logic [NP-1:0] erdy;
    logic          eav;
    rdy = (i == 0) ? rdy0 : rdy1;
    av  = (i == 0) ? av0  : av1;
    rv  = (i == 0) ? rv0  : rv1;
    rd  = (i == 0) ? rd0  : rd1;
    eav = 1'b1;
    for (int p = 0; p < NP; p++) begin
      erdy[p] = (mcnt[i][p] < dep[i]);
      if (mcnt[i][p] == 0) eav = 1'b0;
    end
    check("R3", $sformatf("inst%0d prod_ready", i), 64'(rdy), 64'(erdy));
    check("R4", $sformatf("inst%0d tok_avail", i), 64'(av), 64'(eav));
    check("R5", $sformatf("inst%0d res_valid", i), 64'(rv), 64'(pend[i]));
    if (rv) nres[i]++;
    if (pend[i]) begin
      e = (i == 0) ? expq0.pop_front() : expq1.pop_front();
      check((i == 0) ? "R7" : "R8", $sformatf("inst%0d res_data", i), 64'(rd), 64'(e));
    end else begin
      check("R6", $sformatf("inst%0d idle res_data", i), 64'(rd), 64'd0);
    end
  endtask

  task automatic model_update(input int i);
    logic [W-1:0]  tok [NP];
    logic          f;
    logic [VW-1:0] vec;
    int            ocnt [NP];
    int            ord;
    for (int p = 0; p < NP; p++) begin
      tok[p] = '0;
      for (int k = NP - 1; k >= 0; k--)
        if (xr[k*3 +: 3] == 3'(p)) tok[p] = xd[k*W +: W];
      ocnt[p] = mcnt[i][p];
    end
    ord = mrd[i];
    f = cr;
    for (int p = 0; p < NP; p++) if (ocnt[p] == 0) f = 1'b0;
    if (f) begin
      for (int p = 0; p < NP; p++) vec[p*W +: W] = mq[i][p][ord];
      if (i == 0) expq0.push_back(sort_desc(vec));
      else        expq1.push_back(vec);
      mrd[i] = (ord + 1) % dep[i];
    end
    for (int p = 0; p < NP; p++) begin
      if (pv[p] && ocnt[p] < dep[i]) begin
        mq[i][p][(ord + ocnt[p]) % dep[i]] = tok[p];
        mcnt[i][p] = mcnt[i][p] + 1;
      end
      if (f) mcnt[i][p] = mcnt[i][p] - 1;
    end
    pend[i] = f;
  endtask

  // Driver: checks last cycle's outcome, drives new inputs, pushes expectations.
  task automatic step(input logic [NP-1:0] v, input logic [VW-1:0] d,
                      input logic [NP*3-1:0] rt, input logic c);
    @(negedge clk);
    check_outputs(0);
    check_outputs(1);
    pv = v; xd = d; xr = rt; cr = c;
    model_update(0);
    model_update(1);
  endtask

  function automatic logic [VW-1:0] gen(input int s);
    logic [VW-1:0] r;
    for (int p = 0; p < NP; p++) r[p*W +: W] = 7'((s * 13 + p * 29 + 5) & 127);
    return r;
  endfunction

  localparam logic [NP*3-1:0] RT_ID   = {3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
  localparam logic [NP*3-1:0] RT_REV  = {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5};
  // port0->1, port1->7 (none), port2->1, port3->3, port4->4, port5->5; producers 0 and 2 get 0
  localparam logic [NP*3-1:0] RT_DUP  = {3'd5, 3'd4, 3'd3, 3'd1, 3'd7, 3'd1};

  task automatic drain(input int n);
    for (int s = 0; s < n; s++) step('0, '0, RT_ID, 1'b1);
  endtask

  bit done = 1'b0;

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    pv = '0; xd = '0; xr = RT_ID; cr = 1'b0;
    for (int i = 0; i < 2; i++) begin
      mrd[i] = 0; pend[i] = 1'b0; nres[i] = 0;
      for (int p = 0; p < NP; p++) begin
        mcnt[i][p] = 0; mq[i][p][0] = '0; mq[i][p][1] = '0;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state seen at the ports
    check("R1", "ready0 in reset", 64'(rdy0), 64'h3f);
    check("R1", "avail0 in reset", 64'(av0), 64'd0);
    check("R1", "res_valid1 in reset", 64'(rv1), 64'd0);
    check("R1", "res_data0 in reset", 64'(rd0), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready1 after reset", 64'(rdy1), 64'h3f);
    check("R1", "avail1 after reset", 64'(av1), 64'd0);

    // R9/R10: steady traffic, consumer always ready
    phase = "R9";
    nres[0] = 0; nres[1] = 0;
    for (int s = 0; s < 20; s++) step('1, gen(s), RT_ID, 1'b1);
    check("R9", "depth-2 results in 20 cycles >= 17", 64'(nres[0] >= 17), 64'd1);
    check("R10", "depth-1 results in 20 cycles <= 10", 64'(nres[1] <= 10), 64'd1);
    check("R10", "depth-1 results in 20 cycles >= 8", 64'(nres[1] >= 8), 64'd1);
    drain(3);

    // R2: reversed and duplicated routing, partial valids
    phase = "R2";
    for (int s = 0; s < 6; s++) step('1, gen(40 + s), RT_REV, 1'b1);
    for (int s = 0; s < 6; s++) step('1, gen(50 + s), RT_DUP, 1'b1);
    for (int s = 0; s < 4; s++) step(6'b110111, gen(60 + s), RT_ID, 1'b1);
    drain(2);
    step(6'b001000, gen(70), RT_ID, 1'b1);
    drain(3);

    // R3/R4: consumer stalled, regions fill to capacity, then drain
    phase = "R3";
    for (int s = 0; s < 5; s++) step('1, gen(80 + s), RT_ID, 1'b0);
    phase = "R11";
    drain(5);

    // R11: uneven producer rates, regions wrap independently
    for (int s = 0; s < 18; s++)
      step((s % 3 == 0) ? 6'b111111 : 6'b000001, gen(100 + s), RT_ID, (s % 4) != 1);
    drain(6);

    // R7: ties and extreme values
    phase = "R7";
    step('1, {7'd1, 7'd127, 7'd64, 7'd64, 7'd0, 7'd127}, RT_ID, 1'b1);
    step('1, {7'd5, 7'd5, 7'd5, 7'd5, 7'd5, 7'd5}, RT_ID, 1'b1);
    step('1, {7'd0, 7'd0, 7'd0, 7'd0, 7'd0, 7'd0}, RT_ID, 1'b1);
    drain(4);

    check("R11", "scoreboard empty inst0", 64'(expq0.size()), 64'd0);
    check("R11", "scoreboard empty inst1", 64'(expq1.size()), 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule